// File: doc/BRIEF.md
# Output Crossbar with Spare-Selector Bypass

This block is the output-side interconnect of a logic cluster. Ten logic-block outputs are routed to twelve cluster outputs by twelve main 10:1 selector cells. Every selector is driven by its own select code. The same twelve signals are also returned as feedback lines to the cluster's input-side crossbars.

A fabricated main cell may be defective. The `defect_mask` input models such a cell: a masked cell delivers the wrong value. To work around defects, a pool of spare 10:1 selector cells sits beside the main crossbar. The pool size is set by a parameter and defaults to two. Each cluster output has a 2:1 bypass controlled by its spare-enable bit. When the bit is set, the output takes the spare named by its spare-index field instead of its main cell.

The spares and the bypass selectors are taken to be fault-free. Feedback is tapped after the bypass, so a repair fixes both the output and the feedback line. A configuration check flags two conditions: two enabled outputs claiming the same spare, and a defective main cell left in use. Outputs, feedback and flags are registered once.

Top module: `xbar_up_spare`

## Requirements
- R1: While `rst_n` is low, `clu_out`, `fb_out`, `cfg_dup` and `cfg_unrep` are all 0. Reset is asynchronous.
- R2: With `spare_en[k]`=0 and `defect_mask[k]`=0, `clu_out[k]` one clock later equals `blk_out[c]`. Here c is the 4-bit code `main_sel[4k+3:4k]`. Codes 10 to 15 give 0.
- R3: With `defect_mask[k]`=1 and `spare_en[k]`=0, `clu_out[k]` is the complement of the R2 value. This is the model of a defective main cell.
- R4: With `spare_en[k]`=1, `clu_out[k]` follows spare number i, where i is `spare_idx` bits [k*W +: W] and W = max(1, ceil(log2(N_SPARE))). Spare i picks `blk_out` by the 4-bit code `spare_sel[4i+3:4i]`, with the R2 coding. `defect_mask[k]` has no effect on that output.
- R5: With `spare_en[k]`=1 and a spare index of N_SPARE or more, `clu_out[k]` is 0.
- R6: `fb_out` equals `clu_out` in every cycle, repaired outputs included.
- R7: `cfg_dup` is 1 one clock after two or more enabled outputs carry the same spare index below N_SPARE. Equal indices at or above N_SPARE do not set it.
- R8: `cfg_unrep` is 1 one clock after any output has `defect_mask` set and `spare_en` clear. It is 0 otherwise.
- R9: Any output may use any spare, and N_SPARE defective outputs can be repaired at the same time, each with a distinct spare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_out | input | N_IN | Logic-block output bus |
| main_sel | input | N_OUT*4 | Select codes of the main cells, 4 bits per output |
| spare_sel | input | N_SPARE*4 | Select codes of the spare cells, 4 bits per spare |
| spare_en | input | N_OUT | Per-output bypass enable |
| spare_idx | input | N_OUT*W | Per-output spare index field |
| defect_mask | input | N_OUT | Marks defective main cells |
| clu_out | output | N_OUT | Registered cluster outputs |
| fb_out | output | N_OUT | Registered feedback lines |
| cfg_dup | output | 1 | Two enabled outputs share one spare |
| cfg_unrep | output | 1 | A defective main cell is still in use |

## Verification
Routing is tried with several input patterns:
- Walking and complementary `blk_out` patterns with mixed select codes separate each main cell's pick from its neighbours.
- All-ones inputs with codes 10 to 15 expose any aliasing of out-of-range codes.
- The fault cases cover zero, one, two and three repaired faults, the last on a three-spare instance. These tell a working bypass apart from a main cell leaking through.
- Duplicate-claim, out-of-range-index and unrepaired-mask cases separate the two configuration flags from each other.

// File: rtl/xbar_up_pkg.sv
package xbar_up_pkg;

    // Width of an index field able to name n items (never below one bit)
    function automatic int field_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    typedef struct packed {
        logic dup;
        logic unrep;
    } cfg_flags_t;

endpackage

// File: rtl/xbar_sel_cell.sv
// One N_IN:1 selector; codes at or beyond N_IN yield 0.
module xbar_sel_cell #(
    parameter int N_IN  = 10,
    parameter int SEL_W = 4
) (
    input  logic [N_IN-1:0]  data,
    input  logic [SEL_W-1:0] sel,
    output logic             pick
);
    always_comb begin
        pick = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (sel == SEL_W'(i)) begin
                pick = data[i];
            end
        end
    end
endmodule

// File: rtl/xbar_spare_pool.sv
// Fault-free spare selectors placed beside the main crossbar.
module xbar_spare_pool #(
    parameter int N_IN    = 10,
    parameter int SEL_W   = 4,
    parameter int N_SPARE = 2
) (
    input  logic [N_IN-1:0]          data,
    input  logic [N_SPARE*SEL_W-1:0] sel_bus,
    output logic [N_SPARE-1:0]       val
);
    for (genvar g = 0; g < N_SPARE; g++) begin : g_spare
        xbar_sel_cell #(.N_IN(N_IN), .SEL_W(SEL_W)) u_cell (
            .data (data),
            .sel  (sel_bus[g*SEL_W +: SEL_W]),
            .pick (val[g])
        );
    end
endmodule

// File: rtl/xbar_bypass.sv
// Per-output 2:1 bypass: main cell value or the indexed spare.
module xbar_bypass #(
    parameter int N_OUT   = 12,
    parameter int N_SPARE = 2,
    parameter int SPI_W   = 1
) (
    input  logic [N_OUT-1:0]       main_val,
    input  logic [N_SPARE-1:0]     spare_val,
    input  logic [N_OUT-1:0]       spare_en,
    input  logic [N_OUT*SPI_W-1:0] spare_idx,
    output logic [N_OUT-1:0]       route
);
    always_comb begin
        logic sv;
        for (int k = 0; k < N_OUT; k++) begin
            sv = 1'b0;
            // An index with no matching spare leaves sv at 0
            for (int s = 0; s < N_SPARE; s++) begin
                if (spare_idx[k*SPI_W +: SPI_W] == SPI_W'(s)) begin
                    sv = spare_val[s];
                end
            end
            route[k] = spare_en[k] ? sv : main_val[k];
        end
    end
endmodule

// File: rtl/xbar_cfg_check.sv
// Flags shared spare claims and defective cells left in the path.
module xbar_cfg_check
    import xbar_up_pkg::*;
#(
    parameter int N_OUT   = 12,
    parameter int N_SPARE = 2,
    parameter int SPI_W   = 1
) (
    input  logic [N_OUT-1:0]       spare_en,
    input  logic [N_OUT*SPI_W-1:0] spare_idx,
    input  logic [N_OUT-1:0]       defect_mask,
    output cfg_flags_t             flags
);
    localparam logic [SPI_W:0] IDX_LIM = (SPI_W+1)'(N_SPARE);

    always_comb begin
        flags.dup   = 1'b0;
        flags.unrep = |(defect_mask & ~spare_en);
        for (int i = 0; i < N_OUT; i++) begin
            for (int j = i + 1; j < N_OUT; j++) begin
                if (spare_en[i] && spare_en[j] &&
                    (spare_idx[i*SPI_W +: SPI_W] == spare_idx[j*SPI_W +: SPI_W]) &&
                    ({1'b0, spare_idx[i*SPI_W +: SPI_W]} < IDX_LIM)) begin
                    flags.dup = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/xbar_up_spare.sv
module xbar_up_spare
    import xbar_up_pkg::*;
#(
    parameter  int N_IN    = 10,
    parameter  int N_OUT   = 12,
    parameter  int N_SPARE = 2,
    localparam int SEL_W   = field_w(N_IN),
    localparam int SPI_W   = field_w(N_SPARE)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_IN-1:0]          blk_out,
    input  logic [N_OUT*SEL_W-1:0]   main_sel,
    input  logic [N_SPARE*SEL_W-1:0] spare_sel,
    input  logic [N_OUT-1:0]         spare_en,
    input  logic [N_OUT*SPI_W-1:0]   spare_idx,
    input  logic [N_OUT-1:0]         defect_mask,
    output logic [N_OUT-1:0]         clu_out,
    output logic [N_OUT-1:0]         fb_out,
    output logic                     cfg_dup,
    output logic                     cfg_unrep
);
    localparam logic [SEL_W:0] SEL_LIM = (SEL_W+1)'(N_IN);
    localparam logic [SPI_W:0] IDX_LIM = (SPI_W+1)'(N_SPARE);

    typedef struct packed {
        logic [N_OUT-1:0] clu;
        logic [N_OUT-1:0] fb;
        logic             dup;
        logic             unrep;
        logic             live;
    } state_t;

    state_t st_d, st_q;

    logic [N_OUT-1:0]   main_pick;
    logic [N_OUT-1:0]   main_val;
    logic [N_SPARE-1:0] spare_val;
    logic [N_OUT-1:0]   route;
    cfg_flags_t         flags;

    // Main crossbar; a defective cell returns the wrong level
    for (genvar k = 0; k < N_OUT; k++) begin : g_main
        xbar_sel_cell #(.N_IN(N_IN), .SEL_W(SEL_W)) u_cell (
            .data (blk_out),
            .sel  (main_sel[k*SEL_W +: SEL_W]),
            .pick (main_pick[k])
        );
        assign main_val[k] = main_pick[k] ^ defect_mask[k];
    end

    xbar_spare_pool #(.N_IN(N_IN), .SEL_W(SEL_W), .N_SPARE(N_SPARE)) u_pool (
        .data    (blk_out),
        .sel_bus (spare_sel),
        .val     (spare_val)
    );

    xbar_bypass #(.N_OUT(N_OUT), .N_SPARE(N_SPARE), .SPI_W(SPI_W)) u_bypass (
        .main_val  (main_val),
        .spare_val (spare_val),
        .spare_en  (spare_en),
        .spare_idx (spare_idx),
        .route     (route)
    );

    xbar_cfg_check #(.N_OUT(N_OUT), .N_SPARE(N_SPARE), .SPI_W(SPI_W)) u_check (
        .spare_en    (spare_en),
        .spare_idx   (spare_idx),
        .defect_mask (defect_mask),
        .flags       (flags)
    );

    always_comb begin
        st_d       = st_q;
        st_d.clu   = route;
        st_d.fb    = route;   // feedback tapped after the bypass
        st_d.dup   = flags.dup;
        st_d.unrep = flags.unrep;
        st_d.live  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clu_out   = st_q.clu;
    assign fb_out    = st_q.fb;
    assign cfg_dup   = st_q.dup;
    assign cfg_unrep = st_q.unrep;

    // Per-output properties
    for (genvar k = 0; k < N_OUT; k++) begin : g_chk
        logic [SEL_W-1:0] msel_k;
        logic [SPI_W-1:0] idx_k;
        assign msel_k = main_sel[k*SEL_W +: SEL_W];
        assign idx_k  = spare_idx[k*SPI_W +: SPI_W];

        p_main_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.live && $past(!spare_en[k] && !defect_mask[k])
            |-> st_q.clu[k] == $past(main_pick[k]));

        p_sel_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.live && $past(!spare_en[k] && ({1'b0, msel_k} >= SEL_LIM))
            |-> st_q.clu[k] == $past(defect_mask[k]));

        p_fault_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.live && $past(!spare_en[k] && defect_mask[k])
            |-> st_q.clu[k] != $past(main_pick[k]));

        p_spare_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.live && $past(spare_en[k] && (idx_k == '0))
            |-> st_q.clu[k] == $past(spare_val[0]));

        p_idx_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.live && $past(spare_en[k] && ({1'b0, idx_k} >= IDX_LIM))
            |-> !st_q.clu[k]);

        p_unrep_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.live && $past(defect_mask[k] && !spare_en[k])
            |-> st_q.unrep);
    end

endmodule

// File: tb/xbar_up_spare_bench.sv
module xbar_up_spare_bench;

    typedef struct packed {
        logic [9:0]  blk;
        logic [47:0] msel;
        logic [7:0]  ssel;
        logic [11:0] en;
        logic [11:0] idx;
        logic [11:0] mask;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{10'h2A5, 48'h0123456789AB, 8'h00, 12'h000, 12'h000, 12'h000},
        '{10'h3FF, 48'hFEDCBA987654, 8'h00, 12'h000, 12'h000, 12'h000},
        '{10'h001, 48'h000000000000, 8'h00, 12'h000, 12'h000, 12'h000},
        '{10'h3FE, 48'h000000000000, 8'h00, 12'h000, 12'h000, 12'h001},
        '{10'h155, 48'h0123456789AB, 8'h31, 12'h001, 12'h000, 12'h001},
        '{10'h155, 48'h0123456789AB, 8'h20, 12'h801, 12'h800, 12'h801},
        '{10'h0F0, 48'h000000000000, 8'h05, 12'h003, 12'h000, 12'h000},
        '{10'h0F0, 48'h000000000000, 8'h9F, 12'h002, 12'h002, 12'h004}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  blk_out = '0;
    logic [47:0] main_sel = '0;
    logic [7:0]  spare_sel = '0;
    logic [11:0] spare_en = '0;
    logic [11:0] spare_idx = '0;
    logic [11:0] defect_mask = '0;
    logic [11:0] spare_sel3 = '0;
    logic [23:0] spare_idx3 = '0;

    logic [11:0] clu_out, fb_out, clu3, fb3;
    logic        cfg_dup, cfg_unrep, dup3, unrep3;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xbar_up_spare u_xbar_up_spare (
        .clk(clk), .rst_n(rst_n), .blk_out(blk_out), .main_sel(main_sel),
        .spare_sel(spare_sel), .spare_en(spare_en), .spare_idx(spare_idx),
        .defect_mask(defect_mask), .clu_out(clu_out), .fb_out(fb_out),
        .cfg_dup(cfg_dup), .cfg_unrep(cfg_unrep)
    );

    xbar_up_spare #(.N_SPARE(3)) u_xbar_up_spare_w3 (
        .clk(clk), .rst_n(rst_n), .blk_out(blk_out), .main_sel(main_sel),
        .spare_sel(spare_sel3), .spare_en(spare_en), .spare_idx(spare_idx3),
        .defect_mask(defect_mask), .clu_out(clu3), .fb_out(fb3),
        .cfg_dup(dup3), .cfg_unrep(unrep3)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Reference routing built from R2..R5 for the two-spare instance
    function automatic logic [11:0] m_route(vec_t v);
        logic [11:0] r;
        for (int k = 0; k < 12; k++) begin
            logic [3:0] m, s;
            logic mv, sv;
            m  = v.msel[k*4 +: 4];
            mv = (m < 10) ? v.blk[m] : 1'b0;
            mv = mv ^ v.mask[k];
            s  = v.ssel[v.idx[k]*4 +: 4];
            sv = (s < 10) ? v.blk[s] : 1'b0;
            r[k] = v.en[k] ? sv : mv;
        end
        return r;
    endfunction

    function automatic logic m_dup(vec_t v);
        logic d = 1'b0;
        for (int i = 0; i < 12; i++)
            for (int j = i + 1; j < 12; j++)
                if (v.en[i] && v.en[j] && v.idx[i] == v.idx[j]) d = 1'b1;
        return d;
    endfunction

    task automatic drive(input vec_t v);
        blk_out     = v.blk;
        main_sel    = v.msel;
        spare_sel   = v.ssel;
        spare_en    = v.en;
        spare_idx   = v.idx;
        defect_mask = v.mask;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 clu_out in reset", 32'(clu_out), 32'h0);
        chk("R1 fb_out in reset", 32'(fb_out), 32'h0);
        chk("R1 cfg_dup in reset", 32'(cfg_dup), 32'h0);
        chk("R1 cfg_unrep in reset", 32'(cfg_unrep), 32'h0);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R6 R7 R8 R9
        for (int n = 0; n < NV; n++) begin
            drive(VEC[n]);
            step();
            chk($sformatf("R2/R3/R4/R9 route vec%0d", n), 32'(clu_out), 32'(m_route(VEC[n])));
            chk($sformatf("R6 feedback vec%0d", n), 32'(fb_out), 32'(m_route(VEC[n])));
            chk($sformatf("R7 dup flag vec%0d", n), 32'(cfg_dup), 32'(m_dup(VEC[n])));
            chk($sformatf("R8 unrep flag vec%0d", n), 32'(cfg_unrep),
                32'(|(VEC[n].mask & ~VEC[n].en)));
        end

        // R1: asynchronous reset mid-run
        drive(VEC[1]);
        step();
        rst_n = 1'b0;
        #1;
        chk("R1 clu_out async clear", 32'(clu_out), 32'h0);
        chk("R1 fb_out async clear", 32'(fb_out), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: index beyond spare count on the three-spare instance
        drive('{10'h3FF, 48'h0, 8'h00, 12'h001, 12'h000, 12'h000});
        spare_sel3 = 12'h000;
        spare_idx3 = 24'h000003;
        step();
        chk("R5 out-of-range index gives 0", 32'(clu3), 32'hFFE);
        // R7: equal out-of-range indices do not count as a shared spare
        spare_en   = 12'h003;
        spare_idx3 = 24'h00000F;
        step();
        chk("R5 two outputs out-of-range", 32'(clu3), 32'hFFC);
        chk("R7 no dup for out-of-range index", 32'(dup3), 32'h0);

        // R9: three faults repaired at once with three spares
        blk_out     = 10'h375;
        main_sel    = 48'h0;
        defect_mask = 12'h841;
        spare_en    = 12'h841;
        spare_idx3  = 24'h801000;
        spare_sel3  = 12'h731;
        step();
        chk("R9 three repairs route", 32'(clu3), 32'h7BE);
        chk("R6 three repairs feedback", 32'(fb3), 32'h7BE);
        chk("R8 all faults repaired", 32'(unrep3), 32'h0);
        chk("R7 distinct spares", 32'(dup3), 32'h0);
        // R4: mask is ignored once the bypass is on
        defect_mask = 12'h000;
        step();
        chk("R4 mask ignored under bypass", 32'(clu3), 32'h7BE);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule